// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers interrupt request pulses from a group of peripheral sources and holds each one in a sticky status bit until software acknowledges it. A programmable enable mask selects which of those held bits may reach the processor. The processor interrupt line is driven from a register and rises when at least one held bit is also enabled. A second output, which ignores the mask, reports that something is held at all.

Software reaches the block through a simple register bus with two word registers. Status sits at byte offset 0x00 and mask at byte offset 0x04. To acknowledge, software writes a word with zeros in the positions to clear and ones in the positions to keep. The mask is a plain read/write register. Reads are answered in the same cycle as the strobe. Any other offset reads as all ones and ignores writes.

Top module: `irqc_top`

## Requirements
- R1: A high `irqReq[n]` sampled at a clock edge sets status bit n, and that bit stays set at every later edge until a status write clears it.
- R2: A write to offset 0x00 replaces status with the bitwise AND of its current value and `busWdata`. A 0 bit clears that position and a 1 bit leaves it as it was.
- R3: If a request for bit n arrives at the same edge as a status write that clears bit n, bit n ends up set.
- R4: A write to offset 0x04 loads the mask with `busWdata`. On both registers only bits [NUM_IRQS-1:0] are stored, and bits [31:NUM_IRQS] always read as 0.
- R5: After reset, status and mask are zero and `cpuIrq` and `anyPending` are low.
- R6: `cpuIrq` is high one cycle after an edge at which status AND mask was nonzero, and low one cycle after an edge at which it was zero.
- R7: `anyPending` is high exactly while at least one status bit is set, whatever the mask holds.
- R8: With `busValid` high and `busWrite` low, `busRdata` shows status for address 0x00 and mask for 0x04 in the same cycle. When no read strobe is present, `busRdata` is 0.
- R9: A read at any address other than 0x00 or 0x04 returns 0xFFFFFFFF. A write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | NUM_IRQS | Request from each source, sampled every edge |
| busValid | input | 1 | Single-cycle access strobe |
| busWrite | input | 1 | 1 = write, 0 = read while busValid is high |
| busAddr | input | 32 | Byte address within the register window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the strobe cycle |
| cpuIrq | output | 1 | Registered masked interrupt to the processor |
| anyPending | output | 1 | High while any status bit is set, mask ignored |

## Verification
The bench drives a request into a bit in the same cycle a status write clears that bit. A design that lets the clear win would lose an interrupt. It writes all ones to both registers to catch storage of bits above NUM_IRQS, which would then read back nonzero. It reads and writes near-miss addresses such as 0x01, 0x08 and 0x80000000. Loose decoding would alias these onto a real register or corrupt it. It sets pending bits while the mask is zero, and it removes mask bits while status is held. An `anyPending` that follows the mask would then diverge, and a `cpuIrq` that lags by the wrong number of cycles would show up against the cycle-exact reference.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned BUS_AW = 32;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] STATUS_OFS = 32'h0000_0000;
  localparam logic [BUS_AW-1:0] MASK_OFS   = 32'h0000_0004;

  // Strobes from the access decoder to the register datapath
  typedef struct packed {
    logic rdEn;       // read strobe this cycle
    logic selStatus;  // address hits the status register
    logic selMask;    // address hits the mask register
    logic statusWr;   // acknowledge write to status
    logic maskWr;     // load of the mask
  } ctrlStrobes_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned AW = BUS_AW
) (
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  output ctrlStrobes_t  strb
);

  logic hitStatus;
  logic hitMask;

  // Full-width compare so that no alias of a register exists
  assign hitStatus = (busAddr == AW'(STATUS_OFS));
  assign hitMask   = (busAddr == AW'(MASK_OFS));

  always_comb begin
    strb           = '0;
    strb.rdEn      = busValid && !busWrite;
    strb.selStatus = hitStatus;
    strb.selMask   = hitMask;
    strb.statusWr  = busValid && busWrite && hitStatus;
    strb.maskWr    = busValid && busWrite && hitMask;
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQS = 11,
  parameter int unsigned DW       = BUS_DW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IRQS-1:0] irqReq,
  input  ctrlStrobes_t        strb,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                cpuIrq,
  output logic                anyPending,
  output logic [DW-1:0]       statusQ,
  output logic [DW-1:0]       maskQ
);

  localparam logic [DW-1:0] KEEP = DW'((64'd1 << NUM_IRQS) - 64'd1);

  logic [DW-1:0] reqWide;
  logic [DW-1:0] statusD;
  logic [DW-1:0] maskD;

  assign reqWide = DW'(irqReq);

  // Acknowledge by AND, then OR in new requests so a same-edge request wins
  always_comb begin
    statusD = statusQ;
    if (strb.statusWr) statusD = statusQ & wdata;
    statusD = (statusD | reqWide) & KEEP;
  end

  always_comb begin
    maskD = maskQ;
    if (strb.maskWr) maskD = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      cpuIrq  <= 1'b0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      cpuIrq  <= |(statusQ & maskQ);
    end
  end

  assign anyPending = |statusQ;

  always_comb begin
    rdata = '0;
    if (strb.rdEn) begin
      if (strb.selStatus)    rdata = statusQ;
      else if (strb.selMask) rdata = maskQ;
      else                   rdata = '1;
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IRQS-1:0] irqReq,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [31:0]         busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                cpuIrq,
  output logic                anyPending
);

  ctrlStrobes_t  strb;
  logic [31:0]   statusQ;
  logic [31:0]   maskQ;

  irqc_ctrl #(.AW(32)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  irqc_datapath #(.NUM_IRQS(NUM_IRQS), .DW(32)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqReq     (irqReq),
    .strb       (strb),
    .wdata      (busWdata),
    .rdata      (busRdata),
    .cpuIrq     (cpuIrq),
    .anyPending (anyPending),
    .statusQ    (statusQ),
    .maskQ      (maskQ)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_IRQS = 11
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_IRQS-1:0] irqReq,
  input logic                busValid,
  input logic                busWrite,
  input logic [31:0]         busAddr,
  input logic [31:0]         busRdata,
  input logic                cpuIrq,
  input logic                anyPending,
  input logic [31:0]         statusQ,
  input logic [31:0]         maskQ
);

  logic stWr;
  logic mkWr;
  logic badRd;
  assign stWr  = busValid && busWrite && (busAddr == 32'h0);
  assign mkWr  = busValid && busWrite && (busAddr == 32'h4);
  assign badRd = busValid && !busWrite && (busAddr != 32'h0) && (busAddr != 32'h4);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stWr |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R1

  AST_REQ_SETS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (|irqReq) |=> ((statusQ[NUM_IRQS-1:0] & $past(irqReq)) == $past(irqReq))); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !mkWr |=> $stable(maskQ)); // R9

  AST_CPU_LAGS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cpuIrq == $past(|(statusQ & maskQ)))); // R6

  AST_CPU_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> $past(anyPending)); // R7

  AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rstN)
    badRd |-> (busRdata == 32'hFFFF_FFFF)); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> ((statusQ | maskQ) >> NUM_IRQS) == 32'h0); // R4

endmodule

bind irqc_top irqc_checker #(.NUM_IRQS(NUM_IRQS)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .irqReq     (irqReq),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .busRdata   (busRdata),
  .cpuIrq     (cpuIrq),
  .anyPending (anyPending),
  .statusQ    (statusQ),
  .maskQ      (maskQ)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int N = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  irqReq = '0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [31:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          cpuIrq;
  logic          anyPending;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  longint unsigned mStatus = 0;
  longint unsigned mMask = 0;
  bit mCpu = 0;

  always #5 clk = ~clk;

  irqc_top #(.NUM_IRQS(N)) dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .cpuIrq(cpuIrq), .anyPending(anyPending)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance the model at the edge
  task automatic step(input bit v, input bit w, input logic [31:0] a,
                      input logic [31:0] d, input logic [N-1:0] req, input string tag);
    longint unsigned expRd;
    longint unsigned keep;
    keep = (64'd1 << N) - 1;
    busValid = v; busWrite = w; busAddr = a; busWdata = d; irqReq = req;
    #1;
    if (v && !w) begin
      if (a == 0) expRd = mStatus;
      else if (a == 4) expRd = mMask;
      else expRd = 64'hFFFF_FFFF;
    end else expRd = 0;
    check({tag, " R8/R9 rdata"}, busRdata, expRd);
    check({tag, " R6 cpuIrq"}, cpuIrq, mCpu);
    check({tag, " R7 anyPending"}, anyPending, mStatus != 0);
    @(posedge clk);
    mCpu = (mStatus & mMask) != 0;
    if (v && w && a == 0) mStatus = mStatus & d;
    mStatus = (mStatus | req) & keep;
    if (v && w && a == 4) mMask = d & keep;
    @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    step(1, 0, a, 0, '0, tag);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, '0, tag);
  endtask

  task automatic idle(input logic [N-1:0] req, input string tag);
    step(0, 0, 0, 0, req, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 cpuIrq in reset", cpuIrq, 0);
    check("R5 anyPending in reset", anyPending, 0);
    rstN = 1'b1;
    rd(0, "R5 status zero");
    rd(4, "R5 mask zero");
    // R1/R7: requests latch while mask is zero
    idle(11'h005, "R1 req");
    idle('0, "R1 sticky");
    rd(0, "R1 readback");
    idle('0, "R7 pending unmasked");
    // R4/R6: enable one bit, cpu line follows one cycle late
    wr(4, 32'h0000_0004, "R4 mask");
    idle('0, "R6 lag");
    idle('0, "R6 high");
    // R2: clear bit 2 keep bit 0
    wr(0, 32'hFFFF_FFFB, "R2 ack");
    idle('0, "R2 after");
    rd(0, "R2 readback");
    // R3: request and clear of same bit together
    step(1, 1, 0, 32'h0, 11'h004, "R3 collide");
    rd(0, "R3 readback");
    idle('0, "R3 cpu");
    // R4: wide writes keep only low bits
    wr(4, 32'hFFFF_FFFF, "R4 wide mask");
    rd(4, "R4 mask upper");
    idle(11'h7FF, "R4 all req");
    wr(0, 32'hFFFF_FFFF, "R4 keep all");
    rd(0, "R4 status upper");
    // R9: bad addresses
    wr(32'h8, 32'h0, "R9 bad wr 8");
    wr(32'h1, 32'h0, "R9 bad wr 1");
    wr(32'h8000_0000, 32'h0, "R9 bad wr hi");
    rd(32'h8, "R9 bad rd 8");
    rd(32'h1, "R9 bad rd 1");
    rd(32'h8000_0004, "R9 bad rd alias");
    rd(0, "R9 status intact");
    rd(4, "R9 mask intact");
    // R6/R7: mask off, pending stays, cpu drops
    wr(4, 32'h0, "R6 mask off");
    idle('0, "R6 drop");
    idle('0, "R7 still pending");
    wr(0, 32'h0, "R2 clear all");
    idle('0, "R7 none");
    // R8: no strobe gives zero data
    step(0, 0, 32'h4, 0, '0, "R8 idle rdata");
    step(0, 1, 32'h0, 0, '0, "R8 idle write");
    // mixed patterns
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] r;
      r = N'((i * 37 + 5) % 2048) & N'(i % 3 == 0 ? 11'h7FF : 11'h000);
      case (i % 5)
        0: wr(4, 32'(i * 97), "R4 mix mask");
        1: wr(0, 32'(~(i * 13)), "R2 mix ack");
        2: rd(0, "R8 mix rd");
        3: step(1, 1, 0, 32'(i * 7), r, "R3 mix collide");
        default: idle(r, "R1 mix req");
      endcase
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule